// File: doc/BRIEF.md
# GPIO Pad Controller

This block turns a small set of configuration registers into per-pin pad controls for an eight-pin general-purpose port. For each pin it decides whether the pad's high-side driver or low-side driver is switched on, and whether the weak pull-up is on. It also returns a synchronized copy of each pad's level to the rest of the logic.

Each pin can be set to digital or analog. A digital pin can drive in push-pull or open-drain style. The value a pin drives comes from a port latch bit. When the global crossbar enable is set, a pin whose peripheral-select input is high drives the peripheral's output value instead of its latch bit. The weak pull-up switches on and off by itself according to whether the pin is being driven. One global bit can turn off every pull-up. Software reaches all of the state through a simple register write/read port.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: Out of reset, every pin is digital with open-drain drive, the latch reads 0xFF, and the control register reads 0. Register address 0 is the digital-mode vector (1 = digital). Address 1 is the push-pull vector (1 = push-pull). Address 2 is the latch. Address 3 holds the crossbar enable in bit 0 and the pull-up disable in bit 1.
- R2: An analog pin has its high driver, its low driver and its pull-up all off.
- R3: While the crossbar enable is 0, no pin has either driver on.
- R4: With the crossbar enabled, a digital push-pull pin turns on only its high driver for an output value of 1 and only its low driver for an output value of 0.
- R5: An open-drain pin never turns on its high driver. It turns on its low driver only for an output value of 0.
- R6: A digital pin with neither driver on has its pull-up on, provided the pull-up disable bit is 0.
- R7: A pin that drives its pad low or high has its pull-up off.
- R8: While the pull-up disable bit is 1, every pin's pull-up is off.
- R9: The pad level reaches `pin_in` after two rising clock edges. A digital pin reports the pad level whatever value it is driving.
- R10: An analog pin reads 0 on `pin_in` and in the input register (address 4).
- R11: With the crossbar enabled, a pin whose `periph_sel` bit is 1 drives `periph_out`. Otherwise the pin drives its latch bit.
- R12: A register write takes effect on the next rising edge. Reads are combinational. Addresses 5 to 7 read 0. A write to addresses 4 to 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| periph_sel | input | 8 | Per-pin: peripheral owns the pin |
| periph_out | input | 8 | Peripheral output values |
| pad_in | input | 8 | Raw pad levels |
| pin_in | output | 8 | Synchronized input values |
| pad_drv_hi | output | 8 | High-side driver enable |
| pad_drv_lo | output | 8 | Low-side driver enable |
| pad_pu_en | output | 8 | Weak pull-up enable |

## Verification
Two things can happen in the same cycle: a register write that changes a pin's mode, output mode or latch, and a change on the peripheral inputs that feeds the same pin. The random phase provokes this by writing a random register while it also drives new `periph_sel`, `periph_out` and pad values in that cycle. After the edge, it compares all three drive vectors against a bench model. Input timing is judged separately: the bench changes the pad, checks that `pin_in` still shows the old value after one edge, and checks that it shows the new value, masked by the digital-mode vector, after the second edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned NPINS  = 8;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PP    = 3'd1;
    localparam logic [ADDR_W-1:0] A_LATCH = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_INPUT = 3'd4;

    typedef struct packed {
        logic [NPINS-1:0] dig;
        logic [NPINS-1:0] pp;
        logic [NPINS-1:0] latch;
        logic             xen;
        logic             wpud;
    } cfg_t;

    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
    } sync_t;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NPINS-1:0]  in_val,
    output logic [NPINS-1:0]  rdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (addr)
                A_MODE:  cfg_d.dig   = wdata;
                A_PP:    cfg_d.pp    = wdata;
                A_LATCH: cfg_d.latch = wdata;
                A_CTRL: begin
                    cfg_d.xen  = wdata[0];
                    cfg_d.wpud = wdata[1];
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.dig   <= '1;
            cfg_q.pp    <= '0;
            cfg_q.latch <= '1;
            cfg_q.xen   <= 1'b0;
            cfg_q.wpud  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        unique case (addr)
            A_MODE:  rdata = cfg_q.dig;
            A_PP:    rdata = cfg_q.pp;
            A_LATCH: rdata = cfg_q.latch;
            A_CTRL:  rdata = {{(NPINS-2){1'b0}}, cfg_q.wpud, cfg_q.xen};
            A_INPUT: rdata = in_val;
            default: rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

    // R12: a write to the latch address lands on the next edge
    a_r12_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_LATCH) |=> (cfg_q.latch == $past(wdata)));

    // R12: a write to a read-only or unmapped address leaves the configuration alone
    a_r12_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr >= A_INPUT) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad,
    output logic [NPINS-1:0] synced
);
    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = pad;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign synced = sy_q.s2;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic dig,
    input  logic pp,
    input  logic outv,
    input  logic xen,
    input  logic wpud,
    output logic drv_hi,
    output logic drv_lo,
    output logic pu
);
    logic active;

    always_comb begin
        active = xen & dig;
        drv_hi = active & pp & outv;
        drv_lo = active & ~outv;
        pu     = dig & ~wpud & ~drv_hi & ~drv_lo;
    end

    // R5: an open-drain pin never drives high
    a_r5_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        !pp |-> !drv_hi);

    // R4: both drivers are never on together
    a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_hi && drv_lo));

    // R7: no pull-up while the pad is driven
    a_r7_pu_off_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_hi || drv_lo) |-> !pu);

    // R8: the global disable removes every pull-up
    a_r8_pu_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        wpud |-> !pu);

    // R2: an analog pin is completely passive
    a_r2_analog_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dig |-> !(drv_hi || drv_lo || pu));

    // R3: no drivers without the crossbar enabled
    a_r3_xbar_off: assert property (@(posedge clk) disable iff (!rst_n)
        !xen |-> !(drv_hi || drv_lo));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  periph_sel,
    input  logic [NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pad_drv_hi,
    output logic [NPINS-1:0]  pad_drv_lo,
    output logic [NPINS-1:0]  pad_pu_en
);
    cfg_t             cfg;
    logic [NPINS-1:0] synced;
    logic [NPINS-1:0] in_val;
    logic [NPINS-1:0] out_val;

    gpio_in_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad    (pad_in),
        .synced (synced)
    );

    assign in_val = synced & cfg.dig;
    assign pin_in = in_val;

    gpio_cfg_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .in_val (in_val),
        .rdata  (reg_rdata),
        .cfg    (cfg)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign out_val[i] = (cfg.xen && periph_sel[i]) ? periph_out[i] : cfg.latch[i];

        gpio_pin_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .dig    (cfg.dig[i]),
            .pp     (cfg.pp[i]),
            .outv   (out_val[i]),
            .xen    (cfg.xen),
            .wpud   (cfg.wpud),
            .drv_hi (pad_drv_hi[i]),
            .drv_lo (pad_drv_lo[i]),
            .pu     (pad_pu_en[i])
        );
    end

    // R10: analog pins never report a 1
    a_r10_analog_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_in & ~cfg.dig) == '0);
endmodule

// File: tb/sim_gpio_pad_ctrl.sv
module sim_gpio_pad_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] periph_sel = '0;
    logic [7:0] periph_out = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pin_in, pad_drv_hi, pad_drv_lo, pad_pu_en;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model of the configuration
    logic [7:0] m_dig = 8'hFF, m_pp = 8'h00, m_latch = 8'hFF;
    logic       m_xen = 1'b0, m_wpud = 1'b0;

    always #4 clk = ~clk;

    gpio_pad_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_sel(periph_sel),
        .periph_out(periph_out), .pad_in(pad_in), .pin_in(pin_in),
        .pad_drv_hi(pad_drv_hi), .pad_drv_lo(pad_drv_lo), .pad_pu_en(pad_pu_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] f_out();
        return (m_xen ? periph_sel : 8'h00) & periph_out | ~(m_xen ? periph_sel : 8'h00) & m_latch;
    endfunction
    function automatic logic [7:0] f_hi();
        return {8{m_xen}} & m_dig & m_pp & f_out();
    endfunction
    function automatic logic [7:0] f_lo();
        return {8{m_xen}} & m_dig & ~f_out();
    endfunction
    function automatic logic [7:0] f_pu();
        return m_dig & {8{~m_wpud}} & ~f_hi() & ~f_lo();
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            3'd0: m_dig = d;
            3'd1: m_pp = d;
            3'd2: m_latch = d;
            3'd3: begin m_xen = d[0]; m_wpud = d[1]; end
            default: ;
        endcase
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a; #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic check_drive(input string tag);
        #1;
        check({tag, " drv_hi R4 R5"}, pad_drv_hi, f_hi());
        check({tag, " drv_lo R4 R5"}, pad_drv_lo, f_lo());
        check({tag, " pu R6 R7 R8"}, pad_pu_en, f_pu());
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd("R1 mode", 3'd0, 8'hFF);
        rd("R1 pp", 3'd1, 8'h00);
        rd("R1 latch", 3'd2, 8'hFF);
        rd("R1 ctrl", 3'd3, 8'h00);
        rd("R12 unmapped", 3'd6, 8'h00);
        // R3: crossbar off, latch zero: no drivers, pull-ups on (R6)
        wr(3'd2, 8'h00);
        wr(3'd1, 8'hF0);
        check("R3 drv_hi off", pad_drv_hi, 8'h00);
        check("R3 drv_lo off", pad_drv_lo, 8'h00);
        check("R6 pu idle", pad_pu_en, 8'hFF);
        // enable crossbar
        wr(3'd2, 8'h5A);
        wr(3'd3, 8'h01);
        check("R4 pp high", pad_drv_hi, 8'h50);
        check("R5 od low", pad_drv_lo, 8'hA5);
        check("R7 R6 pu", pad_pu_en, 8'h0A);
        // R2: analog pins
        wr(3'd0, 8'h0F);
        check("R2 hi", pad_drv_hi, 8'h00);
        check("R2 lo", pad_drv_lo, 8'h05);
        check("R2 pu", pad_pu_en, 8'h0A);
        // R8: disable pull-ups
        wr(3'd3, 8'h03);
        check("R8 pu off", pad_pu_en, 8'h00);
        rd("R12 ctrl readback", 3'd3, 8'h03);
        // R12: writes to read-only / unmapped ignored
        wr(3'd4, 8'h00);
        wr(3'd7, 8'h00);
        rd("R12 mode kept", 3'd0, 8'h0F);
        rd("R12 latch kept", 3'd2, 8'h5A);
        // R11: peripheral override
        periph_sel = 8'h0C; periph_out = 8'h04;
        check_drive("R11");
        wr(3'd3, 8'h00);
        check_drive("R11 xbar off");
        // R9 / R10 input timing
        wr(3'd0, 8'hF0);
        pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        check("R9 settle", pin_in, 8'hF0);
        pad_in = 8'h3C;
        @(negedge clk);
        check("R9 one edge old", pin_in, 8'hF0);
        @(negedge clk);
        check("R9 two edges new", pin_in, 8'h30);
        check("R10 analog zero", pin_in & 8'h0F, 8'h00);
        rd("R10 input reg", 3'd4, 8'h30);
        // random phase: writes overlap peripheral/pad changes
        for (int k = 0; k < 400; k++) begin
            periph_sel = 8'($urandom);
            periph_out = 8'($urandom);
            pad_in = 8'($urandom);
            wr(3'($urandom_range(0, 7)), 8'($urandom));
            check_drive("rand");
            if (k % 8 == 0) begin
                @(negedge clk);
                check("R9 R10 rand pin_in", pin_in, pad_in & m_dig);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule